// File: doc/BRIEF.md
# Composite Sync Field Detector

This block recovers frame timing from a single composite-sync wire when no separate vertical sync is available. The raw line is brought into the clock domain, then cleaned so that a level only counts once two consecutive samples agree. A free-running counter times each low excursion of the cleaned signal and the spacing between successive rising edges.

Normal line syncs are narrow. During the vertical interval the line carries wide low pulses. The detector notes that at least one wide pulse has occurred. It then waits for the first narrow pulse after them, and at that pulse's rising edge it emits a single-cycle frame marker. Along with the marker it latches a parity flag. The flag is taken from how far apart the last two rising edges were: a short gap marks the first (odd) field and a long gap marks the second (even) field. Downstream logic can use the cleaned sync output for line counting and pixel capture, which this block does not do.

All thresholds are parameters counted in clock cycles. The defaults suit a 50 MHz clock: 300 cycles for the wide-pulse limit and 1600 cycles for the parity limit.

Top module: `csync_field_detect`

## Requirements
- R1: `csync_clean` takes a new level only when `csync_raw` has shown that level on two consecutive clock samples. A level first sampled at edge t and held appears on `csync_clean` after edge t+3. A one-sample glitch never reaches `csync_clean`.
- R2: After reset, no edge is timed until `csync_clean` has been high. A low-to-high transition seen before that point is ignored, however long the low time was.
- R3: The width of a low pulse is the number of clock cycles `csync_clean` stays low. A pulse is wide when that number is at least LONG_MIN; one cycle fewer is narrow.
- R4: A wide pulse sets the internal vertical-interval flag and by itself never raises `frame_start`.
- R5: The first narrow pulse after one or more wide pulses raises `frame_start` high for exactly one cycle, in the cycle after `csync_clean` returns high.
- R6: Narrow pulses with no wide pulse before them raise no `frame_start`.
- R7: With each `frame_start`, `field_even` is loaded with 1 if the rising-edge spacing (in cycles) ending at that pulse is at least PARITY_MIN, and with 0 otherwise. At all other times it holds its value.
- R8: The vertical-interval flag clears when `frame_start` is issued, so further narrow pulses give no new marker until another wide pulse arrives.
- R9: The width and spacing counters saturate at 2^CNT_W-1 rather than wrap. A low pulse longer than that is still wide.
- R10: During and right after reset, `frame_start`, `field_even` and `csync_clean` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all timing counts its cycles |
| rst_n | input | 1 | Synchronous reset, active low |
| csync_raw | input | 1 | Raw composite sync, asynchronous to clk, active low pulses |
| csync_clean | output | 1 | Synchronized, noise-filtered composite sync |
| frame_start | output | 1 | One-cycle marker at the end of the vertical interval |
| field_even | output | 1 | 1 for the second field, 0 for the first; valid from frame_start on |

## Verification
The frame marker and the parity decision are made on the same rising edge and leave the block in the same cycle. A wrong field value therefore looks like a wrong marker unless both are judged together. The bench sets the gap before the closing narrow pulse one cycle either side of the parity limit, and pulse widths one cycle either side of the wide-pulse limit. On every clock it compares the marker, the parity flag and the cleaned sync against a behavioural model, and at each phase's end it checks the marker count and latched parity against hand-worked values.

// File: rtl/csfd_pkg.sv
// Shared types for the composite sync field detector.
package csfd_pkg;

    // Edge events of the cleaned sync, valid for one cycle each.
    typedef struct packed {
        logic fall;
        logic rise;
    } csfd_edge_t;

endpackage

// File: rtl/csfd_glitch_filter.sv
// Brings the asynchronous sync line into the clock domain and accepts a
// new level only when two consecutive synchronized samples agree.
// Assumes SYNC_STAGES >= 2. Reset holds every stage low.
module csfd_glitch_filter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic clean_out
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] sync_q;
    logic          prior_q;
    logic          clean_q;

    // Synchronizer chain, one flop per stage.
    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= raw_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    // Agreement stage: follow the synchronized value once it repeats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prior_q <= 1'b0;
            clean_q <= 1'b0;
        end else begin
            prior_q <= sync_q[LAST];
            if (sync_q[LAST] == prior_q) clean_q <= sync_q[LAST];
        end
    end

    assign clean_out = clean_q;
endmodule

// File: rtl/csfd_edge_timer.sv
// Finds edges of the cleaned sync and times each low pulse and each
// rise-to-rise interval with saturating counters. Edges count only after
// the line has been seen high once since reset (armed).
module csfd_edge_timer
    import csfd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             level,
    output csfd_edge_t       edges,
    output logic             armed,
    output logic [CNT_W-1:0] low_width,
    output logic [CNT_W-1:0] rise_gap
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic             level_d;
    logic             armed_q;
    logic [CNT_W-1:0] low_q;
    logic [CNT_W-1:0] gap_q;

    // Edge decode from the current and previous level.
    always_comb begin
        edges.fall = level_d & ~level;
        edges.rise = ~level_d & level;
    end

    // Previous level and the armed flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_d <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            level_d <= level;
            armed_q <= armed_q | level;
        end
    end

    // Low-time counter: restarts on a fall, counts low cycles, saturates.
    always_ff @(posedge clk) begin
        if (!rst_n)          low_q <= '0;
        else if (!level) begin
            if (edges.fall)            low_q <= CNT_ONE;
            else if (low_q != CNT_MAX) low_q <= low_q + CNT_ONE;
        end
    end

    // Rise-to-rise counter: restarts on a rise, saturates.
    always_ff @(posedge clk) begin
        if (!rst_n)                gap_q <= '0;
        else if (edges.rise)       gap_q <= CNT_ONE;
        else if (gap_q != CNT_MAX) gap_q <= gap_q + CNT_ONE;
    end

    assign armed     = armed_q;
    assign low_width = low_q;
    assign rise_gap  = gap_q;
endmodule

// File: rtl/csfd_field_fsm.sv
// Classifies each completed low pulse as wide or narrow. The first narrow
// pulse after a wide one gives frame_start and latches the field parity.
// Assumes the counters are sampled in the rising-edge cycle.
module csfd_field_fsm
    import csfd_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int LONG_MIN   = 300,
    parameter int PARITY_MIN = 1600
) (
    input  logic             clk,
    input  logic             rst_n,
    input  csfd_edge_t       edges,
    input  logic             armed,
    input  logic [CNT_W-1:0] low_width,
    input  logic [CNT_W-1:0] rise_gap,
    output logic             frame_start,
    output logic             field_even
);
    localparam logic [CNT_W-1:0] LONG_LIM   = CNT_W'(LONG_MIN);
    localparam logic [CNT_W-1:0] PARITY_LIM = CNT_W'(PARITY_MIN);

    logic seen_wide_q;
    logic start_q;
    logic even_q;
    logic pulse_done;
    logic is_wide;

    // A pulse completes on an armed rising edge.
    always_comb begin
        pulse_done = edges.rise & armed;
        is_wide    = (low_width >= LONG_LIM);
    end

    // Vertical-interval search, frame marker and parity latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_wide_q <= 1'b0;
            start_q     <= 1'b0;
            even_q      <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (pulse_done) begin
                if (is_wide) begin
                    seen_wide_q <= 1'b1;
                end else if (seen_wide_q) begin
                    start_q     <= 1'b1;
                    even_q      <= (rise_gap >= PARITY_LIM);
                    seen_wide_q <= 1'b0;
                end
            end
        end
    end

    assign frame_start = start_q;
    assign field_even  = even_q;
endmodule

// File: rtl/csync_field_detect.sv
// Top of the composite sync field detector: filter, edge timer, field FSM.
// Assumes the sync line idles high with active-low pulses.
module csync_field_detect
    import csfd_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int LONG_MIN    = 300,
    parameter int PARITY_MIN  = 1600,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic csync_raw,
    output logic csync_clean,
    output logic frame_start,
    output logic field_even
);
    csfd_edge_t       edges;
    logic             armed;
    logic [CNT_W-1:0] low_width;
    logic [CNT_W-1:0] rise_gap;

    csfd_glitch_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw_in    (csync_raw),
        .clean_out (csync_clean)
    );

    csfd_edge_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .level     (csync_clean),
        .edges     (edges),
        .armed     (armed),
        .low_width (low_width),
        .rise_gap  (rise_gap)
    );

    csfd_field_fsm #(
        .CNT_W      (CNT_W),
        .LONG_MIN   (LONG_MIN),
        .PARITY_MIN (PARITY_MIN)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .edges       (edges),
        .armed       (armed),
        .low_width   (low_width),
        .rise_gap    (rise_gap),
        .frame_start (frame_start),
        .field_even  (field_even)
    );
endmodule

// File: rtl/csfd_checker.sv
// Temporal checks on the detector's ports, bound to the top module.
module csfd_checker (
    input logic clk,
    input logic rst_n,
    input logic csync_raw,
    input logic csync_clean,
    input logic frame_start,
    input logic field_even
);
    AST_CLEAN_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(csync_clean) |-> ($past(csync_raw, 3) == csync_clean) && ($past(csync_raw, 4) == csync_clean)); // R1

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start); // R5

    AST_START_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> csync_clean && $past(csync_clean) && !$past(csync_clean, 2)); // R5

    AST_PARITY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |-> $stable(field_even)); // R7
endmodule

bind csync_field_detect csfd_checker u_csfd_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .csync_raw   (csync_raw),
    .csync_clean (csync_clean),
    .frame_start (frame_start),
    .field_even  (field_even)
);

// File: tb/csync_field_detect_test.sv
// Bench: behavioural reference model compared every clock, plus phase checks.
module csync_field_detect_test;
    localparam int CW     = 8;
    localparam int LMIN   = 30;
    localparam int PMIN   = 160;
    localparam int MAXC   = (1 << CW) - 1;
    localparam int WD_LIM = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csync_raw = 1'b0;
    logic csync_clean, frame_start, field_even;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    csync_field_detect #(.CNT_W(CW), .LONG_MIN(LMIN), .PARITY_MIN(PMIN)) uut (
        .clk(clk), .rst_n(rst_n), .csync_raw(csync_raw),
        .csync_clean(csync_clean), .frame_start(frame_start), .field_even(field_even)
    );

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    // Reference model state
    int hist[$];
    int m_clean, m_prev, m_armed, m_low, m_gap, m_seen, m_fs, m_fe;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            hist = '{0, 0, 0};
            m_clean = 0; m_prev = 0; m_armed = 0; m_low = 0; m_gap = 0;
            m_seen = 0; m_fs = 0; m_fe = 0;
        end else begin
            int fall, rise, nclean;
            // level accepted once the two oldest held samples agree
            nclean = (hist[1] == hist[0]) ? hist[1] : m_clean;
            fall = (m_prev == 1 && m_clean == 0);
            rise = (m_prev == 0 && m_clean == 1);
            m_fs = 0;
            if (rise && m_armed) begin
                if (m_low >= LMIN) m_seen = 1;
                else if (m_seen == 1) begin
                    m_fs = 1;
                    m_fe = (m_gap >= PMIN) ? 1 : 0;
                    m_seen = 0;
                end
            end
            if (m_clean == 0) m_low = fall ? 1 : ((m_low + 1 > MAXC) ? MAXC : m_low + 1);
            m_gap = rise ? 1 : ((m_gap + 1 > MAXC) ? MAXC : m_gap + 1);
            if (m_clean == 1) m_armed = 1;
            m_prev = m_clean;
            m_clean = nclean;
            hist.push_back(int'(csync_raw));
            void'(hist.pop_front());
        end
    end

    // Per-clock comparison, plus event bookkeeping
    int fs_count = 0;
    int fe_at_fs = 0;
    int clean_low_cycles = 0;
    always @(negedge clk) begin
        if (cyc > 0 && !done) begin
            check("R1 csync_clean", int'(csync_clean), m_clean);
            check("R5 frame_start", int'(frame_start), m_fs);
            check("R7 field_even", int'(field_even), m_fe);
            if (frame_start) begin
                fs_count++;
                fe_at_fs = int'(field_even);
            end
            if (!csync_clean) clean_low_cycles++;
        end
    end

    task automatic hold(int level, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            csync_raw = level[0];
        end
    endtask

    task automatic pulse(int low_n, int high_n);
        hold(0, low_n);
        hold(1, high_n);
    endtask

    task automatic phase_start();
        fs_count = 0;
    endtask

    // Watchdog
    always @(posedge clk) begin
        if (cyc > WD_LIM && !done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected <%0d cycles", cyc, WD_LIM);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        csync_raw = 1'b0;
        repeat (4) @(negedge clk);
        // R10: outputs low while in reset
        check("R10 frame_start", int'(frame_start), 0);
        check("R10 field_even", int'(field_even), 0);
        check("R10 csync_clean", int'(csync_clean), 0);
        @(negedge clk); rst_n = 1'b1;
        check("R10 after release", int'(frame_start) + int'(field_even) + int'(csync_clean), 0);

        // R2/R6: low from reset (wide) then narrow lines: no marker
        phase_start();
        hold(0, 50); hold(1, 100);
        for (int i = 0; i < 4; i++) pulse(10, 90);
        check("R2 R6 no marker", fs_count, 0);

        // R4/R5/R7/R8: odd field
        phase_start();
        for (int i = 0; i < 3; i++) pulse(60, 40);
        check("R4 wide pulses alone", fs_count, 0);
        for (int i = 0; i < 3; i++) pulse(10, 90);
        check("R5 R8 one marker odd", fs_count, 1);
        check("R7 odd parity", fe_at_fs, 0);

        // Even field
        phase_start();
        pulse(60, 40); pulse(60, 40); pulse(60, 240);
        for (int i = 0; i < 3; i++) pulse(10, 90);
        check("R5 R8 one marker even", fs_count, 1);
        check("R7 even parity", fe_at_fs, 1);

        // R9: low of 270 exceeds 8-bit range, must remain wide
        phase_start();
        pulse(270, 40);
        pulse(10, 90); pulse(10, 90);
        check("R9 saturated wide", fs_count, 1);
        check("R9 parity", fe_at_fs, 0);

        // R3 boundary: 29 narrow, 30 wide
        phase_start();
        pulse(LMIN - 1, 40); pulse(10, 90);
        check("R3 width LMIN-1 narrow", fs_count, 0);
        pulse(LMIN, 40); pulse(10, 90);
        check("R3 width LMIN wide", fs_count, 1);

        // R7 boundary: spacing exactly PMIN then PMIN-1
        phase_start();
        pulse(60, PMIN - 10); pulse(10, 90);
        check("R7 spacing PMIN", fe_at_fs, 1);
        pulse(60, PMIN - 11); pulse(10, 90);
        check("R7 spacing PMIN-1", fe_at_fs, 0);
        check("R7 two markers", fs_count, 2);

        // R1: one-sample glitches are filtered out
        phase_start();
        hold(1, 20);
        clean_low_cycles = 0;
        for (int i = 0; i < 5; i++) begin hold(0, 1); hold(1, 20); end
        check("R1 low glitch ignored", clean_low_cycles, 0);
        // high glitch inside a wide pulse keeps it one pulse of 61 cycles
        hold(0, 30); hold(1, 1); hold(0, 30); hold(1, 40);
        pulse(10, 90);
        check("R1 R3 glitched wide pulse", fs_count, 1);

        repeat (10) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule